// File: doc/BRIEF.md
# Prefix-Match Index Table Write Engine

This block is the update path of one stage of a memory-based ternary lookup table for longest-prefix matching. A single write request carries an entry address, a stored pattern and a prefix length. The engine first records the entry in a pattern store. That store is organised as sets of `SW` consecutive entries. The prefix length becomes a thermometer care mask, so the top `plen` bits of the pattern must match and every lower bit is a wildcard.

After the store update, the engine sweeps every possible search key for the affected set, one key per cycle. For each key it forms an `SW`-bit vector that marks which slots of the set would match that key. Vectors that are not zero are deduplicated through a small binary CAM, so each distinct vector receives one compact index. A set of `SW` prefix entries can never produce more than `SW` distinct vectors. On every sweep cycle the engine issues one write command for the index table, addressed by key and set. When the vector is not zero it also issues a write command for the set's indicator table, addressed by the chosen index. `busy` stays high for the whole sweep, and no new request is taken while it is high.

Top module: `lpm_index_writer`

## Requirements
- R1: After synchronous reset, `busy`, `idx_we` and `ind_we` are all low.
- R2: A request with `wr_req` high while `busy` is low is accepted at that clock edge. `busy` is then high for exactly 2^PW cycles and low again afterwards.
- R3: In the k-th busy cycle (k counted from 0), `idx_pat` equals k. `idx_set` equals the accepted address shifted right by log2(SW), that is, the address bits above the slot field.
- R4: During a sweep, bit i of `ind_vec` is 1 only when slot i of the set holds a valid entry and the key equals the stored pattern on the cared bits. The cared bits are the top min(plen, PW) bits. A prefix length of 0 matches every key, and any length above PW acts as PW.
- R5: `idx_vld` is the OR of the vector bits. When `idx_vld` is low, `idx_val` is 0.
- R6: Within one sweep, non-zero vectors are numbered 0, 1, 2, … in the order they first appear as the key rises. A vector that repeats reuses its earlier number. Numbering restarts at 0 with every accepted request.
- R7: During a sweep, `ind_we` equals `idx_vld`. `ind_set` equals `idx_set`, and `ind_idx` equals `idx_val`.
- R8: A request raised while `busy` is high is ignored. It stores nothing, so it never changes a later vector, and it does not extend the sweep.
- R9: A write changes only its own slot. Writing an address again replaces that slot's pattern and length, and the other slots of the set keep their entries.
- R10: While `busy` is low, `idx_we` and `ind_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_addr | input | log2(DEPTH) | Entry address (high bits select the set, low log2(SW) bits select the slot) |
| wr_pat | input | PW | Pattern to store |
| wr_plen | input | log2(PW+1) | Prefix length in cared bits |
| busy | output | 1 | Sweep in progress |
| idx_we | output | 1 | Index table write enable |
| idx_pat | output | PW | Index table row (search key) |
| idx_set | output | log2(DEPTH/SW) | Index table set column |
| idx_vld | output | 1 | Valid bit written to the index table |
| idx_val | output | log2(SW) | Index value written to the index table |
| ind_we | output | 1 | Indicator table write enable |
| ind_set | output | log2(DEPTH/SW) | Which set's indicator table is written |
| ind_idx | output | log2(SW) | Indicator table row |
| ind_vec | output | SW | Indicator vector written |

## Verification
All write commands come straight from registered state. The command for key k is therefore present during the k-th cycle after the accepting edge, and it is committed at the edge that ends that cycle. The bench drives its inputs and samples the outputs on falling edges. It raises a request, waits one falling edge, and then checks the commands of keys 0 to 15 on 16 successive falling edges against a behavioural model of the store and of first-appearance numbering. On the seventeenth falling edge it confirms that `busy` and both write enables have dropped. To test the ignore rule, the request line is held high through a whole sweep. A later sweep of that set then checks that the jammed entry never appeared.

// File: rtl/lpm_wr_pkg.sv
`timescale 1ns/1ps
package lpm_wr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    // Thermometer care mask: the top min(plen, width) bits set, the rest clear.
    // width must stay below 32.
    function automatic int unsigned thermo_mask(input int unsigned width,
                                                input int unsigned plen);
        int unsigned keep;
        keep = (plen > width) ? width : plen;
        return ((32'd1 << keep) - 32'd1) << (width - keep);
    endfunction

endpackage

// File: rtl/lpm_set_store.sv
`timescale 1ns/1ps
module lpm_set_store #(
    parameter int PW    = 4,
    parameter int SW    = 4,
    parameter int NSETS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(NSETS)-1:0] wr_set,
    input  logic [$clog2(SW)-1:0]    wr_slot,
    input  logic [PW-1:0]            wr_pat,
    input  logic [PW-1:0]            wr_mask,
    input  logic [$clog2(NSETS)-1:0] rd_set,
    input  logic [PW-1:0]            probe,
    output logic [SW-1:0]            vec
);
    logic [SW-1:0] vld_q [NSETS];
    logic [PW-1:0] pat_q [NSETS][SW];
    logic [PW-1:0] msk_q [NSETS][SW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) vld_q[s] <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][wr_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pat_q[wr_set][wr_slot] <= wr_pat;
            msk_q[wr_set][wr_slot] <= wr_mask;
        end
    end

    for (genvar i = 0; i < SW; i++) begin : g_cmp
        logic [PW-1:0] diff;
        assign diff   = (pat_q[rd_set][i] ^ probe) & msk_q[rd_set][i];
        assign vec[i] = vld_q[rd_set][i] && (diff == '0);
    end

endmodule

// File: rtl/lpm_dedup_cam.sv
`timescale 1ns/1ps
module lpm_dedup_cam #(
    parameter int SW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic [SW-1:0]         key,
    input  logic                  ins,
    input  logic [$clog2(SW)-1:0] ins_loc,
    output logic                  hit,
    output logic [$clog2(SW)-1:0] hit_loc
);
    localparam int IDX_W = $clog2(SW);

    logic [SW-1:0] ent_q [SW];
    logic [SW-1:0] ent_vld_q;
    logic [SW-1:0] match;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ent_vld_q <= '0;
        end else if (ins) begin
            ent_vld_q[ins_loc] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins) ent_q[ins_loc] <= key;
    end

    for (genvar j = 0; j < SW; j++) begin : g_ent
        assign match[j] = ent_vld_q[j] && (ent_q[j] == key);
    end

    // Lowest matching location wins.
    always_comb begin
        hit_loc = '0;
        for (int j = SW - 1; j >= 0; j--) begin
            if (match[j]) hit_loc = IDX_W'(j);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/lpm_sweep_ctrl.sv
`timescale 1ns/1ps
module lpm_sweep_ctrl
    import lpm_wr_pkg::*;
#(
    parameter int PW = 4,
    parameter int SW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  alloc,
    output logic                  busy,
    output logic [PW-1:0]         pat_cnt,
    output logic [$clog2(SW)-1:0] idx_cnt
);
    sweep_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pat_cnt <= '0;
            idx_cnt <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SWEEP;
                        pat_cnt <= '0;
                        idx_cnt <= '0;
                    end
                end
                ST_SWEEP: begin
                    if (alloc) idx_cnt <= idx_cnt + 1'b1;
                    if (pat_cnt == '1) state_q <= ST_IDLE;
                    pat_cnt <= pat_cnt + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_SWEEP);

endmodule

// File: rtl/lpm_index_writer.sv
`timescale 1ns/1ps
module lpm_index_writer
    import lpm_wr_pkg::*;
#(
    parameter int PW    = 4,
    parameter int SW    = 4,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_req,
    input  logic [$clog2(DEPTH)-1:0]      wr_addr,
    input  logic [PW-1:0]                 wr_pat,
    input  logic [$clog2(PW+1)-1:0]       wr_plen,
    output logic                          busy,
    output logic                          idx_we,
    output logic [PW-1:0]                 idx_pat,
    output logic [$clog2(DEPTH/SW)-1:0]   idx_set,
    output logic                          idx_vld,
    output logic [$clog2(SW)-1:0]         idx_val,
    output logic                          ind_we,
    output logic [$clog2(DEPTH/SW)-1:0]   ind_set,
    output logic [$clog2(SW)-1:0]         ind_idx,
    output logic [SW-1:0]                 ind_vec
);
    localparam int NSETS  = DEPTH / SW;
    localparam int SLOT_W = $clog2(SW);
    localparam int SET_W  = $clog2(NSETS);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              accept;
    logic [SET_W-1:0]  set_q;
    logic [PW-1:0]     wr_mask;
    logic [PW-1:0]     pat_cnt;
    logic [SLOT_W-1:0] idx_cnt;
    logic [SW-1:0]     vec;
    logic              nz;
    logic              hit;
    logic [SLOT_W-1:0] hit_loc;
    logic              alloc;
    logic [SLOT_W-1:0] sel_idx;

    assign accept  = wr_req && !busy;
    assign wr_mask = PW'(thermo_mask(PW, 32'(wr_plen)));

    always_ff @(posedge clk) begin
        if (rst)         set_q <= '0;
        else if (accept) set_q <= wr_addr[ADDR_W-1:SLOT_W];
    end

    lpm_sweep_ctrl #(.PW(PW), .SW(SW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .alloc   (alloc),
        .busy    (busy),
        .pat_cnt (pat_cnt),
        .idx_cnt (idx_cnt)
    );

    lpm_set_store #(.PW(PW), .SW(SW), .NSETS(NSETS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_set  (wr_addr[ADDR_W-1:SLOT_W]),
        .wr_slot (wr_addr[SLOT_W-1:0]),
        .wr_pat  (wr_pat),
        .wr_mask (wr_mask),
        .rd_set  (set_q),
        .probe   (pat_cnt),
        .vec     (vec)
    );

    lpm_dedup_cam #(.SW(SW)) u_cam (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .key     (vec),
        .ins     (alloc),
        .ins_loc (idx_cnt),
        .hit     (hit),
        .hit_loc (hit_loc)
    );

    assign nz    = |vec;
    assign alloc = busy && nz && !hit;

    always_comb begin
        if (!nz)      sel_idx = '0;
        else if (hit) sel_idx = hit_loc;
        else          sel_idx = idx_cnt;
    end

    assign idx_we  = busy;
    assign idx_pat = pat_cnt;
    assign idx_set = set_q;
    assign idx_vld = nz;
    assign idx_val = sel_idx;
    assign ind_we  = busy && nz;
    assign ind_set = set_q;
    assign ind_idx = sel_idx;
    assign ind_vec = vec;

endmodule

// File: rtl/lpm_index_writer_chk.sv
`timescale 1ns/1ps
module lpm_index_writer_chk #(
    parameter int PW    = 4,
    parameter int SW    = 4,
    parameter int DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_req,
    input logic                        busy,
    input logic                        idx_we,
    input logic [PW-1:0]               idx_pat,
    input logic [$clog2(DEPTH/SW)-1:0] idx_set,
    input logic                        idx_vld,
    input logic [$clog2(SW)-1:0]       idx_val,
    input logic                        ind_we,
    input logic [SW-1:0]               ind_vec
);
    localparam int NPAT = 1 << PW;

    logic [PW:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_req) |=> busy);

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && run_cnt < (PW+1)'(NPAT - 1)) |=> busy);

    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && run_cnt == (PW+1)'(NPAT - 1)) |=> !busy);

    p_key_step_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_pat != '1) |=> (idx_pat == PW'($past(idx_pat) + 1'b1)));

    p_set_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(idx_set));

    p_vld_or_r5: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> (idx_vld == (ind_vec != '0)));

    p_zero_idx_r5: assert property (@(posedge clk) disable iff (rst)
        (idx_we && !idx_vld) |-> (idx_val == '0));

    p_first_idx_r6: assert property (@(posedge clk) disable iff (rst)
        (idx_we && idx_pat == '0) |-> (idx_val == '0));

    p_ind_pair_r7: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> (ind_we == idx_vld));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!idx_we && !ind_we));

endmodule

bind lpm_index_writer lpm_index_writer_chk #(.PW(PW), .SW(SW), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .busy    (busy),
    .idx_we  (idx_we),
    .idx_pat (idx_pat),
    .idx_set (idx_set),
    .idx_vld (idx_vld),
    .idx_val (idx_val),
    .ind_we  (ind_we),
    .ind_vec (ind_vec)
);

// File: tb/sim_lpm_index_writer.sv
`timescale 1ns/1ps
module sim_lpm_index_writer;
    localparam int PW    = 4;
    localparam int SW    = 4;
    localparam int DEPTH = 16;
    localparam int NPAT  = 1 << PW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_req = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [3:0] wr_pat = '0;
    logic [2:0] wr_plen = '0;
    logic       busy, idx_we, idx_vld, ind_we;
    logic [3:0] idx_pat, ind_vec;
    logic [1:0] idx_set, idx_val, ind_set, ind_idx;

    int checks = 0;
    int errors = 0;

    bit mv [DEPTH];
    int mp [DEPTH];
    int ml [DEPTH];

    always #10 clk = ~clk;

    lpm_index_writer #(.PW(PW), .SW(SW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_pat(wr_pat), .wr_plen(wr_plen), .busy(busy), .idx_we(idx_we),
        .idx_pat(idx_pat), .idx_set(idx_set), .idx_vld(idx_vld),
        .idx_val(idx_val), .ind_we(ind_we), .ind_set(ind_set),
        .ind_idx(ind_idx), .ind_vec(ind_vec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bmask(input int plen);
        int c;
        c = (plen > PW) ? PW : plen;
        return ((1 << c) - 1) << (PW - c);
    endfunction

    function automatic int exp_vec(input int set, input int key);
        int v;
        v = 0;
        for (int i = 0; i < SW; i++) begin
            int a;
            a = set * SW + i;
            if (mv[a] && (((mp[a] ^ key) & bmask(ml[a])) == 0)) v |= (1 << i);
        end
        return v;
    endfunction

    // One accepted write followed by the full sweep check.
    // jam keeps a request for address 9 high during the sweep (R8).
    task automatic write_sweep(input int addr, input int pat, input int plen,
                               input bit jam, input string vtag);
        int set;
        int seen [SW];
        int nseen;
        int ev;
        int ei;
        set = addr / SW;
        nseen = 0;
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 4'(addr); wr_pat = 4'(pat); wr_plen = 3'(plen);
        mv[addr] = 1'b1; mp[addr] = pat; ml[addr] = plen;
        @(negedge clk);
        if (jam) begin
            wr_addr = 4'd9; wr_pat = 4'hF; wr_plen = 3'd4;
        end else begin
            wr_req = 1'b0;
        end
        for (int k = 0; k < NPAT; k++) begin
            ev = exp_vec(set, k);
            ei = 0;
            if (ev != 0) begin
                ei = -1;
                for (int j = 0; j < nseen; j++) if (seen[j] == ev && ei < 0) ei = j;
                if (ei < 0) begin
                    ei = nseen;
                    seen[nseen] = ev;
                    nseen++;
                end
            end
            chk(busy == 1'b1 && idx_we == 1'b1, "R2 busy/idx_we in sweep", {busy, idx_we}, 3);
            chk(int'(idx_pat) == k, "R3 idx_pat", idx_pat, k);
            chk(int'(idx_set) == set, "R3 idx_set", idx_set, set);
            chk(int'(ind_vec) == ev, vtag, ind_vec, ev);
            chk(idx_vld == (ev != 0), "R5 idx_vld", idx_vld, (ev != 0));
            chk(int'(idx_val) == ei, "R6 idx_val", idx_val, ei);
            chk(ind_we == (ev != 0) && int'(ind_set) == set && int'(ind_idx) == ei,
                "R7 indicator command", {ind_we, ind_set, ind_idx}, {(ev != 0), set[1:0], ei[1:0]});
            if (k == NPAT - 1) wr_req = 1'b0;
            @(negedge clk);
        end
        chk(busy == 1'b0, "R2 busy drops after sweep", busy, 0);
        chk(idx_we == 1'b0 && ind_we == 1'b0, "R10 quiet when idle", {idx_we, ind_we}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2: actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin mv[a] = 0; mp[a] = 0; ml[a] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && idx_we == 1'b0 && ind_we == 1'b0, "R1 reset state",
            {busy, idx_we, ind_we}, 0);
        // R4: prefix 10xx in set 1 slot 1
        write_sweep(5, 4'b1010, 2, 1'b0, "R4 vector prefix-2");
        // R6: exact 1011 in slot 0 gives two distinct vectors
        write_sweep(4, 4'b1011, 4, 1'b0, "R6 vector two indices");
        // R4: plen 0 matches every key
        write_sweep(6, 4'b0101, 0, 1'b0, "R4 vector plen zero");
        // R4: plen above PW clamps to exact match
        write_sweep(7, 4'b1100, 7, 1'b0, "R4 vector plen clamp");
        // R9: overwrite slot 1, others retained
        write_sweep(5, 4'b0000, 1, 1'b0, "R9 vector overwrite");
        // R8: jammed request during sweep of set 2
        write_sweep(8, 4'b0011, 4, 1'b1, "R8 vector during jam");
        write_sweep(10, 4'b0000, 0, 1'b0, "R8 jammed entry absent");
        // R6: four distinct vectors in set 3
        write_sweep(12, 4'b0000, 0, 1'b0, "R6 vector set3 a");
        write_sweep(13, 4'b0000, 1, 1'b0, "R6 vector set3 b");
        write_sweep(14, 4'b0000, 2, 1'b0, "R6 vector set3 c");
        write_sweep(15, 4'b0000, 4, 1'b0, "R6 vector set3 full");
        // R10: idle for a few cycles
        repeat (3) begin
            @(negedge clk);
            chk(busy == 1'b0 && idx_we == 1'b0 && ind_we == 1'b0, "R10 idle",
                {busy, idx_we, ind_we}, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule